// File: doc/BRIEF.md
# Branch Target Address Predictor

This block guesses the next fetch address for an instruction fetch stage. The fetch stage presents its current PC on the predict port. In the same cycle it gets back either a remembered redirection target or the plain sequential address PC+4, since every instruction is 4 bytes wide.

Once a branch or jump has been resolved in execute, the pipeline reports it on the update port. The report carries the PC of the instruction and the address that actually followed it. The table remembers only non-sequential successors. The table is direct-mapped:

- Each slot holds a valid flag, an address tag and a target.
- The slot index comes from the PC bits just above the two byte-offset bits.
- All PC bits above the index form the tag.

A report whose successor turns out to be sequential removes a matching slot, so a branch that stops being taken no longer redirects fetch.

Top module: `nextpc_predictor`

## Requirements
- R1: Reset clears every valid flag, so after reset every predict returns PC+4.
- R2: On a miss the predicted next address is predPc+4. A miss means the slot at index predPc[IDX_W+1:2] is invalid, or its tag differs from predPc[PC_W-1:IDX_W+2].
- R3: An update with updValid=1 and updNext not equal to updPc+4 writes that target and tag into slot updPc[IDX_W+1:2] and sets its valid flag. From the next cycle on, a predict of updPc returns updNext.
- R4: An update with updNext equal to updPc+4 clears the valid flag of the slot at its index when that slot is valid and its tag matches.
- R5: An update with updNext equal to updPc+4 leaves the slot untouched when the tag does not match.
- R6: Two PCs that share an index but differ in tag alias. A predict of one never returns the other's target, and installing one replaces the other.
- R7: When a predict and an update address the same slot in one cycle, the predict returns the slot's contents from before the update.
- R8: While updValid is 0 the table does not change, whatever the other update inputs carry.
- R9: The prediction is combinational. It follows a change of predPc within the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| predPc | input | PC_W | Current fetch PC |
| predNext | output | PC_W | Predicted next fetch address |
| updValid | input | 1 | Resolved-instruction report strobe |
| updPc | input | PC_W | PC of the resolved instruction |
| updNext | input | PC_W | Address that actually followed it |

## Verification
The hardest situations to reach from the ports involve aliasing between PCs that share a slot. One is a sequential report whose tag differs from the resident entry, which must leave that entry alone. The other is a predict that hits the very slot being rewritten in the same cycle. Directed steps build both cases on purpose. The random phase then draws PCs from a pool only a few tags wide, with about half the reports sequential. This pool makes hits, evictions, clears and same-slot collisions frequent.

// File: rtl/nxp_pkg.sv
package nxp_pkg;
  // Strobes from control to the table datapath
  typedef struct packed {
    logic wrEn;   // install target at update index
    logic clrEn;  // drop the entry at update index
  } tbl_strobe_t;
endpackage

// File: rtl/nxp_ctrl.sv
module nxp_ctrl
  import nxp_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic [PC_W-1:0] updNext,
  input  logic            updMatch,
  output tbl_strobe_t     strobe
);
  logic [PC_W-1:0] seqNext;
  logic            isSeq;

  assign seqNext = updPc + PC_W'(4);
  assign isSeq   = (updNext == seqNext);

  always_comb begin
    strobe       = '0;
    strobe.wrEn  = updValid && !isSeq;
    strobe.clrEn = updValid && isSeq && updMatch;
  end
endmodule

// File: rtl/nxp_datapath.sv
module nxp_datapath
  import nxp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = PC_W - IDX_W - 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  tbl_strobe_t      strobe,
  input  logic [PC_W-1:0]  predPc,
  output logic [PC_W-1:0]  predNext,
  input  logic [IDX_W-1:0] updIdx,
  input  logic [TAG_W-1:0] updTag,
  input  logic [PC_W-1:0]  updNext,
  output logic             updMatch
);
  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ    [ENTRIES];
  logic [PC_W-1:0]    targetQ [ENTRIES];

  logic [IDX_W-1:0] predIdx;
  logic [TAG_W-1:0] predTag;
  logic             predHit;
  logic [PC_W-1:0]  predSeq;

  // Lookup: reads registered state only, so a same-cycle update is unseen
  assign predIdx  = predPc[IDX_W+1:2];
  assign predTag  = predPc[PC_W-1:IDX_W+2];
  assign predSeq  = predPc + PC_W'(4);
  assign predHit  = validQ[predIdx] && (tagQ[predIdx] == predTag);
  assign predNext = predHit ? targetQ[predIdx] : predSeq;

  assign updMatch = validQ[updIdx] && (tagQ[updIdx] == updTag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (strobe.wrEn) begin
      validQ[updIdx] <= 1'b1;
    end else if (strobe.clrEn) begin
      validQ[updIdx] <= 1'b0;
    end
  end

  // Per-slot payload storage, no reset needed behind the valid flag
  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic sel;
    assign sel = strobe.wrEn && (updIdx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (sel) begin
        tagQ[e]    <= updTag;
        targetQ[e] <= updNext;
      end
    end
  end

  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (validQ == '0));

  // R3
  install_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> (validQ[$past(updIdx)] && targetQ[$past(updIdx)] == $past(updNext)
                     && tagQ[$past(updIdx)] == $past(updTag)));

  // R4
  clear_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrEn |=> !validQ[$past(updIdx)]);

  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wrEn && !strobe.clrEn) |=> $stable(validQ));
endmodule

// File: rtl/nextpc_predictor.sv
module nextpc_predictor
  import nxp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] predPc,
  output logic [PC_W-1:0] predNext,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic [PC_W-1:0] updNext
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - 2;

  tbl_strobe_t      strobe;
  logic             updMatch;
  logic [IDX_W-1:0] updIdx;
  logic [TAG_W-1:0] updTag;

  assign updIdx = updPc[IDX_W+1:2];
  assign updTag = updPc[PC_W-1:IDX_W+2];

  nxp_ctrl #(.PC_W(PC_W)) u_ctrl (
    .updValid (updValid),
    .updPc    (updPc),
    .updNext  (updNext),
    .updMatch (updMatch),
    .strobe   (strobe)
  );

  nxp_datapath #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .predPc   (predPc),
    .predNext (predNext),
    .updIdx   (updIdx),
    .updTag   (updTag),
    .updNext  (updNext),
    .updMatch (updMatch)
  );
endmodule

// File: tb/nextpc_predictor_tb.sv
`timescale 1ns/1ps
module nextpc_predictor_tb;
  localparam int PC_W    = 32;
  localparam int ENTRIES = 16;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [PC_W-1:0] predPc = '0;
  logic [PC_W-1:0] predNext;
  logic            updValid = 1'b0;
  logic [PC_W-1:0] updPc = '0;
  logic [PC_W-1:0] updNext = '0;

  int total = 0;
  int bad = 0;

  // Reference table indexed by slot
  logic            mValid [ENTRIES];
  logic [PC_W-1:0] mPc    [ENTRIES];
  logic [PC_W-1:0] mTgt   [ENTRIES];

  always #2 clk = ~clk;

  nextpc_predictor #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_dut (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predNext(predNext),
    .updValid(updValid), .updPc(updPc), .updNext(updNext)
  );

  function automatic int slotOf(input logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic logic sameTag(input logic [PC_W-1:0] a, input logic [PC_W-1:0] b);
    return a[PC_W-1:IDX_W+2] == b[PC_W-1:IDX_W+2];
  endfunction

  function automatic logic [PC_W-1:0] expPred(input logic [PC_W-1:0] pc);
    int s = slotOf(pc);
    if (mValid[s] && sameTag(mPc[s], pc)) return mTgt[s];
    return pc + 4;
  endfunction

  function automatic logic isHit(input logic [PC_W-1:0] pc);
    int s = slotOf(pc);
    return mValid[s] && sameTag(mPc[s], pc);
  endfunction

  task automatic modelUpdate(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] nxt);
    int s = slotOf(pc);
    if (nxt != pc + 4) begin
      mValid[s] = 1'b1; mPc[s] = pc; mTgt[s] = nxt;
    end else if (mValid[s] && sameTag(mPc[s], pc)) begin
      mValid[s] = 1'b0;
    end
  endtask

  task automatic check(input logic [PC_W-1:0] exp, input string req);
    total++;
    if (predNext !== exp) begin
      bad++;
      $display("FAIL %s: predPc=%h actual=%h expected=%h", req, predPc, predNext, exp);
    end
  endtask

  // One cycle: drive at negedge, check before the edge, then commit
  task automatic step(input logic [PC_W-1:0] pc, input logic uv,
                      input logic [PC_W-1:0] upc, input logic [PC_W-1:0] unx,
                      input string req);
    @(negedge clk);
    predPc = pc; updValid = uv; updPc = upc; updNext = unx;
    #1;
    check(expPred(pc), req);
    @(posedge clk);
    if (uv) modelUpdate(upc, unx);
  endtask

  localparam logic [PC_W-1:0] PA = 32'h0000_0040;
  localparam logic [PC_W-1:0] PB = 32'h0000_0080; // same slot as PA, other tag

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < ENTRIES; i++) begin
      mValid[i] = 1'b0; mPc[i] = '0; mTgt[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: empty table after reset
    step(PA, 1'b0, '0, '0, "R1");
    step(32'h0000_1234, 1'b0, '0, '0, "R1");
    // R7: install while predicting the same slot shows old contents
    step(PA, 1'b1, PA, 32'h0000_0200, "R7");
    // R3: visible from the next cycle
    step(PA, 1'b0, '0, '0, "R3");
    // R9: change predPc inside the cycle
    @(negedge clk); predPc = PA + 4; #1; check(PA + 8, "R9");
    predPc = PA; #1; check(32'h0000_0200, "R9");
    // R6: alias misses, then replaces
    step(PB, 1'b0, '0, '0, "R6");
    step(PB, 1'b1, PB, 32'h0000_0300, "R6");
    step(PA, 1'b0, '0, '0, "R6");
    step(PB, 1'b0, '0, '0, "R6");
    // R5: sequential report with other tag leaves PB alone
    step(PB, 1'b1, PA, PA + 4, "R5");
    step(PB, 1'b0, '0, '0, "R5");
    // R4: sequential report with matching tag clears
    step(PB, 1'b1, PB, PB + 4, "R4");
    step(PB, 1'b0, '0, '0, "R4");
    // R8: disabled update does nothing
    step(PA, 1'b0, PA, 32'h0000_0900, "R8");
    step(PA, 1'b0, '0, '0, "R8");
    // R2: miss of unrelated PC
    step(32'h0000_7000, 1'b0, '0, '0, "R2");

    // Random phase over a narrow PC pool
    for (int n = 0; n < 3000; n++) begin
      logic [PC_W-1:0] pp, up, un;
      logic uv;
      pp = PC_W'($urandom_range(0, 127)) << 2;
      up = PC_W'($urandom_range(0, 127)) << 2;
      uv = ($urandom_range(0, 3) != 0);
      un = ($urandom_range(0, 1) == 0) ? up + 4 : (PC_W'($urandom_range(0, 4095)) << 2);
      if ($urandom_range(0, 7) == 0) pp = up;
      step(pp, uv, up, un, isHit(pp) ? "R3" : "R2");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule